// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block walks a ring of transmit buffer descriptors held in system memory and feeds the buffers they describe to a frame sender. Each descriptor takes two 32-bit words at consecutive word addresses. The first word is the buffer's byte address. The second word carries the following fields:

| Bit(s) | Meaning |
|--------|---------|
| 31 | used (owned by software) |
| 30 | wrap (last entry of the ring) |
| 15 | last buffer of a frame |
| 10:0 | buffer length |

Software writes a ring base address and then a control word. The controller keeps a transmit-go flag and a ring pointer, and it fetches descriptors through a single request/acknowledge memory port.

Each buffer that is free goes to the sender as an address, a length and a last flag. The sender reports one outcome per frame: done, collision, retry limit or underrun. When a frame succeeds, the controller writes the first descriptor of that frame back with the used bit set. A collision restarts the frame from its first descriptor. A used descriptor found in the middle of a frame is an error: it pulses the error output, which marks the frame's checksum bad, and it rewinds the pointer to the base. A used descriptor found at the start of a frame only stops transmission, and the pointer keeps its place. A halt request waits until the frame in flight has ended. A pause input holds back new frames.

The state machine has six states:
- S_IDLE: waiting for go.
- S_RD0: fetching word 0.
- S_RD1: fetching word 1.
- S_HAND: offering the buffer.
- S_WAIT: waiting for the frame outcome.
- S_WB: writing back the used bit.

Transitions:
- S_IDLE goes to S_RD0 when go is set, no halt is pending and no pause is in force. The current pointer is then recorded as the frame's first descriptor.
- S_RD0 goes to S_RD1 on acknowledge.
- S_RD1 goes to S_HAND on acknowledge when the used bit is clear. It goes to S_IDLE when the used bit is set.
- S_HAND goes to S_RD0 on accept of a non-last buffer, or to S_WAIT on accept of a last buffer.
- S_WAIT goes to S_WB on done, to S_RD0 on collision, or to S_IDLE on retry limit or underrun.
- S_WB goes to S_IDLE on acknowledge.
- A disable or a base write sends any state to S_IDLE at once.

Top module: `txq_ctrl`

## Requirements
- R1: After reset `tx_stat` is 0 (go clear, no sticky flags), and `mem_req` and `snd_valid` are low.
- R2: A write to `ctrl_wdata` with bit 3 (enable) and bit 9 (start) set, and bit 10 clear, sets go (`tx_stat` bit 3). The controller then reads word 0 at the pointer and word 1 at pointer+4.
- R3: A used bit (word 1 bit 31) read at the start of a frame clears go and sets `tx_stat` bit 0. The pointer stays, so the next start reads that same descriptor first.
- R4: A free descriptor is offered as `snd_addr`, `snd_len` (word 1 bits 10:0) and `snd_last` (word 1 bit 15), held until `snd_ready`. The pointer then advances by 8.
- R5: On `snd_done`, word 1 of the frame's first descriptor is rewritten with bit 31 set and its other bits unchanged, and `tx_stat` bit 4 is set.
- R6: After a descriptor with word 1 bit 30 (wrap) set, or after 1024 descriptors without a wrap, the pointer returns to the base.
- R7: On `snd_collision`, transmission restarts from the first descriptor of the frame.
- R8: A used bit read after at least one buffer of the frame gives a one-cycle `tx_er` pulse, clears go, sets `tx_stat` bit 5 and returns the pointer to the base.
- R9: `snd_retry_lim` or `snd_underrun` clears go, sets `tx_stat` bit 1 or bit 2 respectively, and returns the pointer to the base.
- R10: A control write with bits 3 and 10 set lets the frame in progress complete, including its write-back, and then clears go without fetching a further descriptor.
- R11: A control write with bit 3 clear stops at once, clears go and returns the pointer to the base.
- R12: A write on `base_wr` clears go and points the pointer at the new base.
- R13: While `pause_en` and `pause_in` are both high, no new frame starts and go stays set.
- R14: Writing start again while a frame is in flight leaves that frame's buffers and write-back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: bit 3 enable, bit 9 start, bit 10 halt |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | AW | New ring base byte address |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Memory read data |
| snd_valid | output | 1 | Buffer offered to sender |
| snd_addr | output | AW | Buffer byte address |
| snd_len | output | LEN_W | Buffer length |
| snd_last | output | 1 | Buffer ends the frame |
| snd_ready | input | 1 | Sender accepts buffer |
| snd_done | input | 1 | Frame sent successfully |
| snd_collision | input | 1 | Frame hit a collision; resend |
| snd_retry_lim | input | 1 | Frame failed after too many retries |
| snd_underrun | input | 1 | Frame failed by underrun |
| pause_en | input | 1 | Pause function enabled |
| pause_in | input | 1 | Pause requested |
| tx_er | output | 1 | One-cycle error pulse (bad checksum) |
| tx_stat | output | 8 | Status: b0 used-stop, b1 retry, b2 underrun, b3 go, b4 sent, b5 mid-frame used |

## Verification
The assertions rely on the memory raising `mem_ack` only while `mem_req` is high. They also rely on the sender reporting exactly one outcome pulse, and only after it has accepted the last buffer of a frame, and on software writing the base only when aborting. The bench models the memory and the sender at the falling clock edge. Its memory acknowledges once per request. Its sender accepts an offered buffer in the next cycle and pulses its chosen outcome one cycle after the last buffer, or stays silent while a stop is being tested. Base and disable writes are issued only while the controller waits on an outcome or sits idle.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_HAND, S_WAIT, S_WB} txq_st_t;
    typedef enum logic [1:0] {P_HOLD, P_BASE, P_ADV, P_FIRST} txq_pcmd_t;

    localparam int CTL_EN    = 3;
    localparam int CTL_START = 9;
    localparam int CTL_HALT  = 10;
    localparam int W1_USED   = 31;
    localparam int W1_WRAP   = 30;
    localparam int W1_LAST   = 15;
endpackage

// File: rtl/txq_ptr.sv
module txq_ptr
    import txq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RING_MAX = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  txq_pcmd_t     cmd,
    input  logic          wrap,
    input  logic          mark_first,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] first_ptr
);
    localparam int IW = (RING_MAX > 1) ? $clog2(RING_MAX) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(RING_MAX - 1);

    logic [AW-1:0] base_q, ptr_q, first_q;
    logic [IW-1:0] idx_q, fidx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            ptr_q   <= '0;
            first_q <= '0;
            idx_q   <= '0;
            fidx_q  <= '0;
        end else if (base_wr) begin
            base_q <= base_wdata;
            ptr_q  <= base_wdata;
            idx_q  <= '0;
        end else begin
            if (mark_first) begin
                first_q <= ptr_q;
                fidx_q  <= idx_q;
            end
            unique case (cmd)
                P_BASE: begin
                    ptr_q <= base_q;
                    idx_q <= '0;
                end
                P_ADV: begin
                    if (wrap || idx_q == IDX_LAST) begin
                        ptr_q <= base_q;
                        idx_q <= '0;
                    end else begin
                        ptr_q <= ptr_q + AW'(8);
                        idx_q <= idx_q + 1'b1;
                    end
                end
                P_FIRST: begin
                    ptr_q <= first_q;
                    idx_q <= fidx_q;
                end
                default: ;
            endcase
        end
    end

    assign ptr       = ptr_q;
    assign first_ptr = first_q;

    // R11 / R8 / R9: a rewind command from the state machine lands on the base
    p_rewind_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == P_BASE && !base_wr) |=> ptr_q == base_q);

    // R7: a restart command puts the pointer back on the recorded first entry
    p_restart_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == P_FIRST && !base_wr && !mark_first) |=> ptr_q == first_q);
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
    import txq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    input  logic             base_wr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             snd_ready,
    input  logic             snd_done,
    input  logic             snd_collision,
    input  logic             snd_retry_lim,
    input  logic             snd_underrun,
    input  logic             pause_en,
    input  logic             pause_in,
    input  logic [AW-1:0]    ptr,
    input  logic [AW-1:0]    first_ptr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             snd_valid,
    output logic [AW-1:0]    snd_addr,
    output logic [LEN_W-1:0] snd_len,
    output logic             snd_last,
    output logic             tx_er,
    output logic [7:0]       tx_stat,
    output txq_pcmd_t        pcmd,
    output logic             wrap,
    output logic             mark_first
);
    txq_st_t st_q, st_n;
    logic go_q, halt_pend_q, in_frame_q, tx_er_q;
    logic used_q, retry_q, urun_q, ok_q, mid_q;
    logic [AW-1:0] w0_q;
    logic [31:0] w1_q, first_w1_q;
    logic go_clr, f_used, f_mid, f_retry, f_urun, f_ok;

    wire dis     = ctrl_wr && !ctrl_wdata[CTL_EN];
    wire abort   = dis || base_wr;
    wire start_w = ctrl_wr && ctrl_wdata[CTL_EN] && ctrl_wdata[CTL_START] && !ctrl_wdata[CTL_HALT];
    wire halt_w  = ctrl_wr && ctrl_wdata[CTL_EN] && ctrl_wdata[CTL_HALT];
    wire paused  = pause_en && pause_in;

    logic unused_bits;
    assign unused_bits = ^{ctrl_wdata[31:11], ctrl_wdata[8:4], ctrl_wdata[2:0],
                           w1_q[31], w1_q[29:16], w1_q[14:LEN_W]};

    // next-state and command decode
    always_comb begin
        st_n       = st_q;
        pcmd       = P_HOLD;
        mark_first = 1'b0;
        go_clr     = 1'b0;
        f_used     = 1'b0;
        f_mid      = 1'b0;
        f_retry    = 1'b0;
        f_urun     = 1'b0;
        f_ok       = 1'b0;
        if (abort) begin
            st_n   = S_IDLE;
            go_clr = 1'b1;
            if (dis) pcmd = P_BASE;
        end else begin
            unique case (st_q)
                S_IDLE: if (go_q && !halt_pend_q && !paused) begin
                    st_n       = S_RD0;
                    mark_first = 1'b1;
                end
                S_RD0: if (mem_ack) st_n = S_RD1;
                S_RD1: if (mem_ack) begin
                    if (mem_rdata[W1_USED]) begin
                        st_n   = S_IDLE;
                        go_clr = 1'b1;
                        if (in_frame_q) begin
                            f_mid = 1'b1;
                            pcmd  = P_BASE;
                        end else begin
                            f_used = 1'b1;
                        end
                    end else begin
                        st_n = S_HAND;
                    end
                end
                S_HAND: if (snd_ready) begin
                    pcmd = P_ADV;
                    st_n = w1_q[W1_LAST] ? S_WAIT : S_RD0;
                end
                S_WAIT: begin
                    if (snd_done) begin
                        st_n = S_WB;
                    end else if (snd_collision) begin
                        pcmd = P_FIRST;
                        st_n = S_RD0;
                    end else if (snd_retry_lim || snd_underrun) begin
                        pcmd    = P_BASE;
                        go_clr  = 1'b1;
                        f_retry = snd_retry_lim;
                        f_urun  = snd_underrun;
                        st_n    = S_IDLE;
                    end
                end
                S_WB: if (mem_ack) begin
                    f_ok = 1'b1;
                    st_n = S_IDLE;
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // state register and tracked flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            go_q        <= 1'b0;
            halt_pend_q <= 1'b0;
            in_frame_q  <= 1'b0;
            tx_er_q     <= 1'b0;
            used_q      <= 1'b0;
            retry_q     <= 1'b0;
            urun_q      <= 1'b0;
            ok_q        <= 1'b0;
            mid_q       <= 1'b0;
            w0_q        <= '0;
            w1_q        <= '0;
            first_w1_q  <= '0;
        end else begin
            st_q <= st_n;
            if (st_q == S_IDLE && halt_pend_q) begin
                go_q        <= 1'b0;
                halt_pend_q <= 1'b0;
            end
            if (halt_w) halt_pend_q <= 1'b1;
            if (start_w) begin
                go_q        <= 1'b1;
                halt_pend_q <= 1'b0;
                used_q      <= 1'b0;
                retry_q     <= 1'b0;
                urun_q      <= 1'b0;
                ok_q        <= 1'b0;
                mid_q       <= 1'b0;
            end
            if (go_clr)  go_q    <= 1'b0;
            if (f_used)  used_q  <= 1'b1;
            if (f_retry) retry_q <= 1'b1;
            if (f_urun)  urun_q  <= 1'b1;
            if (f_ok)    ok_q    <= 1'b1;
            if (f_mid)   mid_q   <= 1'b1;
            tx_er_q <= f_mid;
            if (st_q == S_RD0 && mem_ack) w0_q <= mem_rdata[AW-1:0];
            if (st_q == S_RD1 && mem_ack) begin
                w1_q <= mem_rdata;
                if (!in_frame_q) first_w1_q <= mem_rdata;
            end
            if (st_n == S_IDLE || pcmd == P_FIRST) in_frame_q <= 1'b0;
            else if (st_q == S_HAND && snd_ready)  in_frame_q <= 1'b1;
        end
    end

    // outputs from state
    always_comb begin
        mem_req   = (st_q == S_RD0) || (st_q == S_RD1) || (st_q == S_WB);
        mem_we    = (st_q == S_WB);
        mem_addr  = ptr;
        if (st_q == S_RD1) mem_addr = ptr + AW'(4);
        if (st_q == S_WB)  mem_addr = first_ptr + AW'(4);
        mem_wdata = {1'b1, first_w1_q[30:0]};
        snd_valid = (st_q == S_HAND);
        snd_addr  = w0_q;
        snd_len   = w1_q[LEN_W-1:0];
        snd_last  = w1_q[W1_LAST];
        wrap      = w1_q[W1_WRAP];
        tx_er     = tx_er_q;
        tx_stat   = {2'b00, mid_q, ok_q, go_q, urun_q, retry_q, used_q};
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));

    p_hand_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && !snd_ready && !abort) |=> (snd_valid && $stable(snd_addr) && $stable(snd_len)));

    p_wb_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[W1_USED]);

    p_er_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_er |=> !tx_er);

    p_base_go_r12: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> !tx_stat[3]);

    p_pause_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && paused && !start_w) |=> (st_q == S_IDLE && $stable(go_q)));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LEN_W    = 11,
    parameter int RING_MAX = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    input  logic             base_wr,
    input  logic [AW-1:0]    base_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             snd_valid,
    output logic [AW-1:0]    snd_addr,
    output logic [LEN_W-1:0] snd_len,
    output logic             snd_last,
    input  logic             snd_ready,
    input  logic             snd_done,
    input  logic             snd_collision,
    input  logic             snd_retry_lim,
    input  logic             snd_underrun,
    input  logic             pause_en,
    input  logic             pause_in,
    output logic             tx_er,
    output logic [7:0]       tx_stat
);
    txq_pcmd_t     pcmd;
    logic          wrap, mark_first;
    logic [AW-1:0] ptr, first_ptr;

    txq_ptr #(.AW(AW), .RING_MAX(RING_MAX)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .cmd        (pcmd),
        .wrap       (wrap),
        .mark_first (mark_first),
        .ptr        (ptr),
        .first_ptr  (first_ptr)
    );

    txq_fsm #(.AW(AW), .LEN_W(LEN_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr       (ctrl_wr),
        .ctrl_wdata    (ctrl_wdata),
        .base_wr       (base_wr),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .snd_ready     (snd_ready),
        .snd_done      (snd_done),
        .snd_collision (snd_collision),
        .snd_retry_lim (snd_retry_lim),
        .snd_underrun  (snd_underrun),
        .pause_en      (pause_en),
        .pause_in      (pause_in),
        .ptr           (ptr),
        .first_ptr     (first_ptr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .snd_valid     (snd_valid),
        .snd_addr      (snd_addr),
        .snd_len       (snd_len),
        .snd_last      (snd_last),
        .tx_er         (tx_er),
        .tx_stat       (tx_stat),
        .pcmd          (pcmd),
        .wrap          (wrap),
        .mark_first    (mark_first)
    );

    // R1: nothing is requested while the controller is not going and idle after reset
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_stat[3] && !mem_req && !ctrl_wr) |=> !snd_valid);
endmodule

// File: tb/txq_ctrl_bench.sv
module txq_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        ctrl_wr = 0, base_wr = 0;
    logic [31:0] ctrl_wdata = 0, base_wdata = 0;
    logic        mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        snd_valid, snd_last, snd_ready = 0;
    logic [31:0] snd_addr;
    logic [10:0] snd_len;
    logic        snd_done = 0, snd_collision = 0, snd_retry_lim = 0, snd_underrun = 0;
    logic        pause_en = 0, pause_in = 0;
    logic        tx_er;
    logic [7:0]  tx_stat;

    txq_ctrl u_txq_ctrl (.*);

    localparam logic [31:0] C_START = 32'h0000_0208;
    localparam logic [31:0] C_HALT  = 32'h0000_0408;
    localparam logic [31:0] C_OFF   = 32'h0000_0000;

    int checks = 0, errors = 0;
    logic [31:0] mem [0:4095];
    logic [31:0] rd_log[$], hand_log[$], hl_len[$], wr_a[$], wr_d[$];
    int outcome = 0;
    bit coll_seen = 0, pend = 0;
    int er_cnt = 0;

    // memory model
    always @(negedge clk) begin
        if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_a.push_back(mem_addr);
                wr_d.push_back(mem_wdata);
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
                rd_log.push_back(mem_addr);
            end
        end
    end

    // sender model
    always @(negedge clk) begin
        snd_done <= 0; snd_collision <= 0; snd_retry_lim <= 0; snd_underrun <= 0;
        if (tx_er) er_cnt <= er_cnt + 1;
        if (pend) begin
            pend <= 0;
            case (outcome)
                0: snd_done <= 1;
                1: if (!coll_seen) begin snd_collision <= 1; coll_seen <= 1; end
                   else snd_done <= 1;
                2: snd_retry_lim <= 1;
                3: snd_underrun <= 1;
                default: ;
            endcase
        end
        if (snd_ready) snd_ready <= 0;
        else if (snd_valid) begin
            snd_ready <= 1;
            hand_log.push_back(snd_addr);
            hl_len.push_back({21'd0, snd_len});
            if (snd_last) pend <= 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] w1f(bit used, bit wrp, bit last, int len);
        return {used, wrp, 14'd0, last, 4'd0, len[10:0]};
    endfunction

    task automatic put(input int a, input logic [31:0] b, input logic [31:0] w1);
        mem[a >> 2]       = b;
        mem[(a >> 2) + 1] = w1;
    endtask

    task automatic ctl(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic setbase(input logic [31:0] v);
        @(negedge clk); base_wr = 1; base_wdata = v;
        @(negedge clk); base_wr = 0;
    endtask

    task automatic clr_logs();
        rd_log.delete(); hand_log.delete(); hl_len.delete(); wr_a.delete(); wr_d.delete();
        coll_seen = 0; er_cnt = 0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        repeat (3) @(negedge clk);
        while (tx_stat[3] && n < 40000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
        chk(n < 40000, {req, " timeout"}, n, 0);
    endtask

    task automatic wait_hand(input int k);
        int n = 0;
        while (hand_log.size() < k && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        chk(tx_stat == 8'h00, "R1 stat", tx_stat, 0);
        chk(!mem_req && !snd_valid, "R1 idle outputs", {mem_req, snd_valid}, 0);
    endtask

    task automatic t_single();
        clr_logs(); outcome = 0;
        put(32'h100, 32'hA000, w1f(0, 0, 1, 64));
        put(32'h108, 32'hA100, w1f(1, 0, 1, 8));
        setbase(32'h100); ctl(C_START);
        chk(tx_stat[3], "R2 go set", tx_stat, 8'h08);
        wait_idle("R2");
        chk(rd_log.size() >= 2 && rd_log[0] == 32'h100 && rd_log[1] == 32'h104, "R2 fetch order",
            rd_log.size() >= 2 ? rd_log[1] : 0, 32'h104);
        chk(hand_log.size() == 1 && hand_log[0] == 32'hA000 && hl_len[0] == 64, "R4 handoff",
            hand_log.size() ? hand_log[0] : 0, 32'hA000);
        chk(wr_a.size() == 1 && wr_a[0] == 32'h104 && wr_d[0] == w1f(1, 0, 1, 64), "R5 write-back",
            wr_d.size() ? wr_d[0] : 0, w1f(1, 0, 1, 64));
        chk(tx_stat == 8'h11, "R3 R5 status", tx_stat, 8'h11);
        chk(rd_log[rd_log.size()-1] == 32'h10C, "R4 pointer +8", rd_log[rd_log.size()-1], 32'h10C);
        clr_logs();
        put(32'h108, 32'hA100, w1f(0, 0, 1, 8));
        put(32'h110, 32'h0, w1f(1, 0, 1, 0));
        ctl(C_START); wait_idle("R3");
        chk(rd_log.size() > 0 && rd_log[0] == 32'h108, "R3 resume same descriptor",
            rd_log.size() ? rd_log[0] : 0, 32'h108);
    endtask

    task automatic t_coll();
        clr_logs(); outcome = 1;
        put(32'h200, 32'hB000, w1f(0, 0, 0, 10));
        put(32'h208, 32'hB100, w1f(0, 0, 1, 20));
        put(32'h210, 32'h0, w1f(1, 0, 1, 0));
        setbase(32'h200); ctl(C_START); wait_idle("R7");
        chk(hand_log.size() == 4 && hand_log[2] == 32'hB000 && hand_log[3] == 32'hB100,
            "R7 restart from first", hand_log.size(), 4);
        chk(wr_a.size() == 1 && wr_a[0] == 32'h204, "R5 first descriptor only",
            wr_a.size() ? wr_a[0] : 0, 32'h204);
    endtask

    task automatic t_mid();
        clr_logs(); outcome = 0;
        put(32'h300, 32'hC000, w1f(0, 0, 0, 5));
        put(32'h308, 32'hC100, w1f(1, 0, 1, 5));
        setbase(32'h300); ctl(C_START); wait_idle("R8");
        chk(er_cnt == 1, "R8 tx_er one pulse", er_cnt, 1);
        chk(tx_stat == 8'h20, "R8 status", tx_stat, 8'h20);
        clr_logs();
        put(32'h308, 32'hC100, w1f(0, 0, 1, 5));
        ctl(C_START); wait_idle("R8");
        chk(rd_log.size() > 0 && rd_log[0] == 32'h300, "R8 pointer to base",
            rd_log.size() ? rd_log[0] : 0, 32'h300);
    endtask

    task automatic t_fail();
        clr_logs(); outcome = 2;
        put(32'h400, 32'hD000, w1f(0, 0, 1, 3));
        put(32'h408, 32'hD100, w1f(0, 0, 1, 3));
        setbase(32'h400); ctl(C_START); wait_idle("R9");
        chk(tx_stat == 8'h02, "R9 retry status", tx_stat, 8'h02);
        clr_logs(); outcome = 3;
        ctl(C_START); wait_idle("R9");
        chk(rd_log.size() > 0 && rd_log[0] == 32'h400, "R9 pointer to base",
            rd_log.size() ? rd_log[0] : 0, 32'h400);
        chk(tx_stat == 8'h04 && wr_a.size() == 0, "R9 underrun status", tx_stat, 8'h04);
    endtask

    task automatic t_wrap();
        clr_logs(); outcome = 0;
        put(32'h500, 32'hE000, w1f(0, 0, 1, 1));
        put(32'h508, 32'hE100, w1f(0, 1, 1, 1));
        put(32'h510, 32'hE200, w1f(0, 0, 1, 1));
        setbase(32'h500); ctl(C_START); wait_idle("R6");
        chk(rd_log.size() == 6 && rd_log[4] == 32'h500, "R6 wrap to base",
            rd_log.size(), 6);
    endtask

    task automatic t_halt();
        clr_logs(); outcome = 0;
        put(32'h600, 32'hF000, w1f(0, 0, 0, 2));
        put(32'h608, 32'hF100, w1f(0, 0, 1, 2));
        put(32'h610, 32'hF200, w1f(0, 0, 1, 2));
        setbase(32'h600); ctl(C_START);
        wait_hand(1); ctl(C_HALT);
        chk(tx_stat[3], "R10 go held during frame", tx_stat, 8'h08);
        wait_idle("R10");
        chk(hand_log.size() == 2 && wr_a.size() == 1 && wr_a[0] == 32'h604, "R10 frame completes",
            hand_log.size(), 2);
        chk(rd_log.size() == 4, "R10 no further fetch", rd_log.size(), 4);
    endtask

    task automatic t_disable();
        clr_logs(); outcome = 4;
        put(32'h700, 32'h1100, w1f(0, 0, 1, 4));
        setbase(32'h700); ctl(C_START);
        wait_hand(1); repeat (4) @(negedge clk);
        ctl(C_OFF);
        chk(!tx_stat[3], "R11 go cleared", tx_stat, 0);
        clr_logs(); outcome = 0;
        ctl(C_START); wait_idle("R11");
        chk(rd_log.size() > 0 && rd_log[0] == 32'h700, "R11 pointer to base",
            rd_log.size() ? rd_log[0] : 0, 32'h700);
    endtask

    task automatic t_base();
        clr_logs(); outcome = 4;
        put(32'h780, 32'h1200, w1f(0, 0, 1, 4));
        put(32'h800, 32'h1300, w1f(0, 0, 1, 4));
        put(32'h808, 32'h0, w1f(1, 0, 1, 0));
        setbase(32'h780); ctl(C_START);
        wait_hand(1); repeat (4) @(negedge clk);
        setbase(32'h800);
        chk(!tx_stat[3], "R12 go cleared", tx_stat, 0);
        clr_logs(); outcome = 0;
        ctl(C_START); wait_idle("R12");
        chk(rd_log.size() > 0 && rd_log[0] == 32'h800, "R12 new base",
            rd_log.size() ? rd_log[0] : 0, 32'h800);
    endtask

    task automatic t_pause();
        clr_logs(); outcome = 0;
        put(32'h900, 32'h1400, w1f(0, 0, 1, 7));
        put(32'h908, 32'h0, w1f(1, 0, 1, 0));
        setbase(32'h900); pause_en = 1; pause_in = 1;
        ctl(C_START); repeat (20) @(negedge clk);
        chk(rd_log.size() == 0 && tx_stat[3], "R13 paused, go kept", rd_log.size(), 0);
        pause_in = 0; wait_idle("R13");
        pause_en = 0;
        chk(hand_log.size() == 1 && hand_log[0] == 32'h1400, "R13 resumes",
            hand_log.size() ? hand_log[0] : 0, 32'h1400);
    endtask

    task automatic t_restart();
        clr_logs(); outcome = 0;
        put(32'hA00, 32'h1500, w1f(0, 0, 0, 9));
        put(32'hA08, 32'h1600, w1f(0, 0, 1, 9));
        put(32'hA10, 32'h0, w1f(1, 0, 1, 0));
        setbase(32'hA00); ctl(C_START);
        wait_hand(1); ctl(C_START); wait_idle("R14");
        chk(hand_log.size() == 2 && hand_log[1] == 32'h1600 && wr_a.size() == 1 && wr_a[0] == 32'hA04,
            "R14 restart harmless", hand_log.size(), 2);
    endtask

    task automatic t_roll();
        clr_logs(); outcome = 0;
        for (int i = 0; i < 1024; i++) put(32'h1000 + 8 * i, 32'h2000 + i, w1f(0, 0, 1, 1));
        put(32'h3000, 32'h0, w1f(1, 0, 1, 0));
        setbase(32'h1000); ctl(C_START); wait_idle("R6");
        chk(hand_log.size() == 1024, "R6 rollover count", hand_log.size(), 1024);
        chk(rd_log.size() >= 2 && rd_log[rd_log.size()-2] == 32'h1000 &&
            rd_log[rd_log.size()-1] == 32'h1004, "R6 rollover to base",
            rd_log[rd_log.size()-2], 32'h1000);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_coll();
        t_mid();
        t_fail();
        t_wrap();
        t_halt();
        t_disable();
        t_base();
        t_pause();
        t_restart();
        t_roll();
        $display("CHECKS %0d ERRORS %0d", checks, errors + 0);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule